// File: doc/BRIEF.md
# ADC Offset Calibration and Output Coding Stage

This stage sits between a 10-bit converter and the logic that uses its results. Raw results arrive in offset-binary coding, where mid-scale (512) stands for zero input. A one-shot calibration measures the converter's own error at zero input. Software raises a calibration-start pulse. The stage then sets its calibration flag and drives a request output that makes the converter model short its inputs to zero. The first sample accepted while the flag is set is kept as a signed offset (sample minus mid-scale) and is not passed on. The flag then clears by itself.

Every later sample has the stored offset subtracted. The difference is clamped to the 10-bit code range. The result is then coded as straight binary, or as two's complement by inverting its top bit. A soft-reset input clears the offset, the calibration flag and the output stage.

Both data sides use valid/ready. A sample is taken when `in_valid` and `in_ready` are both high. A result is handed over when `out_valid` and `out_ready` are both high. While `out_ready` is low, the output holds its value. Because the stage has a single output register, `in_ready` is high only when that register is empty or is being emptied in the same cycle. A stalled consumer therefore stops the converter side with no extra cycle of slack.

Top module: `adc_offset_fmt`

## Requirements
- R1: After `rst_n` is released, `out_valid` and `cal_busy` are low, and the offset is zero: a first sample X with `fmt_bin`=1 comes out as X.
- R2: A cycle with `cal_start`=1 and `soft_rst`=0 sets `cal_busy` and `cal_zero_req` on the next clock. If a calibration sample is taken in the same cycle, `cal_start` still wins.
- R3: The first sample accepted while `cal_busy` is high is stored as offset = sample − 512. It produces no output, and `cal_busy` is low on the next clock.
- R4: Outside calibration, an accepted sample S gives the corrected value C = S − offset, clamped to the range 0..1023.
- R5: With `fmt_bin`=1 the output is C. With `fmt_bin`=0 the output is C with bit 9 inverted (two's complement). `fmt_bin` is sampled in the cycle the sample is accepted.
- R6: A sample accepted at one clock edge appears on `out_data` with `out_valid` high right after that edge (one cycle of latency).
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold. `in_ready` = !`soft_rst` && (!`out_valid` || `out_ready`).
- R8: `soft_rst`=1 clears the offset to zero and clears `cal_busy` and `out_valid` on the next clock. No sample is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of offset, calibration flag and output |
| cal_start | input | 1 | Pulse: begin an offset calibration |
| fmt_bin | input | 1 | 1 = straight binary output, 0 = two's complement |
| cal_busy | output | 1 | Calibration flag; clears itself once the offset is stored |
| cal_zero_req | output | 1 | Asks the converter to force its inputs to zero |
| in_valid | input | 1 | Raw sample valid |
| in_ready | output | 1 | Stage can take a sample |
| in_data | input | 10 | Raw offset-binary sample |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | 10 | Corrected, coded result |

## Verification
Samples are sent at full rate, with random gaps, and under random back-pressure. These three patterns separate a correct ready equation and hold behaviour from a stage that drops or repeats results. Calibrations use zero-input readings above, at and below mid-scale, so positive, zero and negative offsets are all covered. These are followed by samples at the code extremes, which separate clamping from wrap-around at both ends. The format bit is toggled between samples, and soft reset is pulsed in the middle of a calibration. This shows that the coding is taken per sample and that the stored offset returns to zero.

// File: rtl/adc_ofs_pkg.sv
package adc_ofs_pkg;
  typedef enum logic {
    FMT_TWOS = 1'b0,
    FMT_BIN  = 1'b1
  } out_fmt_e;
endpackage

// File: rtl/ofs_cal_ctrl.sv
module ofs_cal_ctrl #(
  parameter int DW = 10,
  localparam int OW = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 cal_start,
  input  logic                 take,
  input  logic [DW-1:0]        sample,
  output logic                 busy,
  output logic signed [OW-1:0] offset
);
  localparam logic [OW-1:0] MID = OW'(1) << (DW - 1);

  logic cal_take;
  assign cal_take = take && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      offset <= '0;
    end else if (soft_rst) begin
      busy   <= 1'b0;
      offset <= '0;
    end else begin
      if (cal_take) begin
        offset <= $signed({1'b0, sample} - MID);
        busy   <= 1'b0;
      end
      if (cal_start) busy <= 1'b1;
    end
  end
endmodule

// File: rtl/ofs_sub_sat.sv
module ofs_sub_sat #(
  parameter int DW = 10,
  localparam int OW = DW + 1,
  localparam int XW = DW + 2
) (
  input  logic [DW-1:0]        raw,
  input  logic signed [OW-1:0] offset,
  output logic [DW-1:0]        corr
);
  localparam logic signed [XW-1:0] MAXC = XW'((1 << DW) - 1);

  logic signed [XW-1:0] diff;

  always_comb begin
    diff = $signed({2'b00, raw}) - {offset[OW-1], offset};
    if (diff < 0)          corr = '0;
    else if (diff > MAXC)  corr = '1;
    else                   corr = diff[DW-1:0];
  end
endmodule

// File: rtl/ofs_out_stage.sv
module ofs_out_stage
  import adc_ofs_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          load,
  input  logic [DW-1:0] corr,
  input  out_fmt_e      fmt,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic [DW-1:0] coded;

  always_comb begin
    coded = corr;
    if (fmt == FMT_TWOS) coded[DW-1] = ~corr[DW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (soft_rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= coded;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_offset_fmt.sv
module adc_offset_fmt
  import adc_ofs_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          cal_start,
  input  logic          fmt_bin,
  output logic          cal_busy,
  output logic          cal_zero_req,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int OW = DW + 1;

  logic                 take;
  logic                 busy;
  logic signed [OW-1:0] offset;
  logic [DW-1:0]        corr;
  out_fmt_e             fmt;

  assign in_ready     = !soft_rst && (!out_valid || out_ready);
  assign take         = in_valid && in_ready;
  assign cal_busy     = busy;
  assign cal_zero_req = busy;
  assign fmt          = fmt_bin ? FMT_BIN : FMT_TWOS;

  ofs_cal_ctrl #(.DW(DW)) u_cal (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cal_start(cal_start),
    .take(take), .sample(in_data), .busy(busy), .offset(offset)
  );

  ofs_sub_sat #(.DW(DW)) u_sub (
    .raw(in_data), .offset(offset), .corr(corr)
  );

  ofs_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .load(take && !busy),
    .corr(corr), .fmt(fmt), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

module adc_offset_fmt_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          cal_start,
  input logic          cal_busy,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);
  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !soft_rst) |=> (out_valid && $stable(out_data)));

  a_r3_cal_sample_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cal_busy && (!out_valid || out_ready)) |=> !out_valid);

  a_r3_cal_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cal_busy && !cal_start) |=> !cal_busy);

  a_r8_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!cal_busy && !out_valid));

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !cal_busy) |=> out_valid);

  a_r2_cal_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_start && !soft_rst) |=> cal_busy);
endmodule

bind adc_offset_fmt adc_offset_fmt_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cal_start(cal_start),
  .cal_busy(cal_busy), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/adc_offset_fmt_tb.sv
module adc_offset_fmt_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0, cal_start = 1'b0, fmt_bin = 1'b1;
  logic       in_valid = 1'b0, out_ready = 1'b1;
  logic [9:0] in_data = '0;
  logic       cal_busy, cal_zero_req, in_ready, out_valid;
  logic [9:0] out_data;

  int tests = 0, fails = 0;
  int m_ov = 0, m_od = 0, m_busy = 0, m_off = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_offset_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cal_start(cal_start),
    .fmt_bin(fmt_bin), .cal_busy(cal_busy), .cal_zero_req(cal_zero_req),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare DUT state with model (called at negedge, after the edge)
  task automatic compare(input string ctx);
    chk({ctx, " R6 out_valid"}, int'(out_valid), m_ov);
    if (m_ov != 0) chk({ctx, " R4 R5 out_data"}, int'(out_data), m_od);
    chk({ctx, " R2 R3 cal_busy"}, int'(cal_busy), m_busy);
    chk({ctx, " R2 cal_zero_req"}, int'(cal_zero_req), m_busy);
  endtask

  // drive one cycle of inputs, check ready, advance model
  task automatic step(input bit v, input int d, input bit rdy, input bit cal,
                      input bit fb, input bit sr);
    int acc, c;
    @(negedge clk);
    compare("cycle");
    in_valid = v; in_data = 10'(d); out_ready = rdy; cal_start = cal;
    fmt_bin = fb; soft_rst = sr;
    #1;
    chk("R7 in_ready", int'(in_ready), int'(!sr && (m_ov == 0 || rdy)));
    acc = (!sr && v && (m_ov == 0 || rdy)) ? 1 : 0;
    if (sr) begin
      m_ov = 0; m_busy = 0; m_off = 0;
    end else begin
      if (m_ov != 0 && rdy) m_ov = 0;
      if (acc != 0) begin
        if (m_busy != 0) begin
          m_off = d - 512; m_busy = 0;
        end else begin
          c = d - m_off;
          if (c < 0) c = 0;
          if (c > 1023) c = 1023;
          m_od = fb ? c : (c ^ 512);
          m_ov = 1;
        end
      end
      if (cal) m_busy = 1;
    end
  endtask

  task automatic calibrate(input int zero_code);
    step(0, 0, 1, 1, 1, 0);
    step(1, zero_code, 1, 0, 1, 0);   // R3 calibration sample
    step(0, 0, 1, 0, 1, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 cal_busy", int'(cal_busy), 0);
    step(1, 321, 1, 0, 1, 0);            // R1 zero offset: 321 out as 321
    step(0, 0, 1, 0, 1, 0);
    // two's complement coding R5
    step(1, 512, 1, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0);
    step(1, 1023, 1, 0, 1, 0);
    // positive offset, clamp at zero R4
    calibrate(600);
    step(1, 50, 1, 0, 1, 0);
    step(1, 1023, 1, 0, 1, 0);
    step(1, 700, 1, 0, 0, 0);
    // negative offset, clamp at top R4
    calibrate(400);
    step(1, 1000, 1, 0, 1, 0);
    step(1, 0, 1, 0, 1, 0);
    // zero offset calibration
    calibrate(512);
    step(1, 777, 1, 0, 1, 0);
    // R2 cal_start wins against same-cycle calibration sample
    step(0, 0, 1, 1, 1, 0);
    step(1, 530, 1, 1, 1, 0);
    step(1, 520, 1, 0, 1, 0);
    step(1, 520, 1, 0, 1, 0);
    // R7 stall with data held
    step(1, 100, 0, 0, 1, 0);
    step(1, 200, 0, 0, 1, 0);
    step(1, 300, 0, 0, 0, 0);
    step(1, 300, 1, 0, 0, 0);
    // R8 soft reset mid-calibration and with offset held
    calibrate(650);
    step(0, 0, 1, 1, 1, 0);
    step(1, 900, 1, 0, 1, 1);
    step(1, 900, 1, 0, 1, 0);            // offset back to zero
    step(0, 0, 1, 0, 1, 0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(($urandom_range(0, 3) != 0), $urandom_range(0, 1023),
           (i < 1000) ? 1'b1 : ($urandom_range(0, 2) != 0),
           (r < 3), $urandom_range(0, 1), (r == 99));
    end
    @(negedge clk);
    compare("final");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule